// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block sits in the command path of an SDRAM controller. It takes one read request at a time, naming a bank, a starting column and a word count. It drives the READ command and then stops the burst early, either with a burst-stop or with a precharge. The stop is placed so that exactly the requested number of words comes back. Every other command-bus cycle carries NOP, and the data mask stays low for the whole read.

The stop cycle is derived from the CAS latency that is programmed when the request is accepted. The returned words are sampled from the DQ bus and passed on as a stream. Each word carries a valid strobe, and the final requested word also carries a last flag. A burst-stop on a fixed-length burst is not legal while auto precharge is active. When a request asks for one, the block raises an error pulse, issues no stop and lets the whole programmed burst come back.

Top module: `sdram_rd_trunc`

## Requirements
- R1: One cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), the command bus carries READ ({ras_n,cas_n,we_n} = 3'b101) with `sd_ba` = bank and `sd_addr[COL_W-1:0]` = column. `sd_addr[AP_BIT]` equals the auto-precharge request for fixed-length bursts and is 0 for full-page bursts.
- R2: With a CAS latency of CL (1, 2 or 3) and N requested words, the stop command is issued CL-1 cycles before the cycle whose closing edge samples the last wanted word. That is N cycles after the READ cycle, for every supported CL.
- R3: A full-page burst (`cfg_full_page` = 1) is always truncated after N words, and the auto-precharge request has no effect on it: no error is raised and A10 stays low.
- R4: When `req_stop_pre` = 1, the stop command is PRECHARGE (3'b010) on the request's bank with `sd_addr[AP_BIT]` = 0. When it is 0, the stop command is burst-stop (3'b110).
- R5: A burst-stop request on a fixed-length burst with auto precharge set and N below the burst length raises `trunc_err` for one cycle, in the READ cycle. No stop command is issued, and all burst-length words are returned. A precharge request in the same case raises no error.
- R6: For a fixed-length burst (length 2^`cfg_bl_sel`: 1, 2, 4 or 8) with N at or above the burst length, no stop command is issued and exactly burst-length words are returned.
- R7: Every command-bus cycle that carries neither the READ nor the stop command, idle cycles included, carries NOP (3'b111) with `sd_cs_n` low.
- R8: `sd_dqm` is low in every cycle.
- R9: Word k (counted from 0) of a read is the value on `sd_dq_in` at the clock edge that ends cycle READ+CL+k. It appears on `rd_data` with `rd_valid` high in the following cycle, in order and with no gaps. `rd_last` is high only with the final word.
- R10: `req_ready` is low from acceptance until the cycle of the final word and is high again in that cycle, so a new request can be accepted there.
- R11: After reset, the command bus carries NOP, `req_ready` is high, and `rd_valid`, `rd_last` and `trunc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 (0 treated as 1) |
| cfg_bl_sel | input | 2 | Fixed burst length select, length = 2^value |
| cfg_full_page | input | 1 | Device set to full-page bursts |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_bank | input | BANK_W | Bank to read |
| req_col | input | COL_W | Starting column |
| req_len_m1 | input | COL_W | Requested words minus one |
| req_stop_pre | input | 1 | 1: stop with PRECHARGE, 0: stop with burst-stop |
| req_auto_pre | input | 1 | READ with auto precharge |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | DATA_W/8 | Data mask |
| sd_dq_in | input | DATA_W | Read data from the device |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DATA_W | Captured word |
| rd_last | output | 1 | Final requested word |
| trunc_err | output | 1 | Illegal burst-stop refused |

## Verification
A wrong stop-cycle computation shows up as a stop command on the bus one or more cycles off from N cycles after the READ. It can be seen within at most CL+N cycles of acceptance. A wrong capture window or word count shifts `rd_data` against the DQ pattern, or moves `rd_last`, and this shows on the first bad word. The legality decision is visible at the READ cycle itself through `trunc_err` and A10, and later through the absence of a stop and the number of returned words. A stuck busy state shows as `req_ready` failing to come back with `rd_last`.

// File: rtl/sdram_rd_trunc_pkg.sv
package sdram_rd_trunc_pkg;
   // command encoding as {ras_n, cas_n, we_n}
   typedef enum logic [2:0] {
      CMD_NOP  = 3'b111,
      CMD_READ = 3'b101,
      CMD_BST  = 3'b110,
      CMD_PRE  = 3'b010
   } sd_cmd_e;
endpackage

// File: rtl/sdram_rd_trunc_plan.sv
module sdram_rd_trunc_plan #(
   parameter int COL_W = 9,
   parameter int CNT_W = COL_W + 2
) (
   input  logic [1:0]       cas_lat,
   input  logic [1:0]       bl_sel,
   input  logic             full_page,
   input  logic [COL_W-1:0] len_m1,
   input  logic             stop_pre,
   input  logic             auto_pre,
   output logic [1:0]       cl_eff,
   output logic             ap_bit,
   output logic             do_stop,
   output logic             err,
   output logic [CNT_W-1:0] last_at,
   output logic [CNT_W-1:0] stop_at
);
   logic [COL_W-1:0] bl_tab [4];
   logic [COL_W-1:0] bl_m1;
   logic [COL_W-1:0] words_m1;
   logic             trunc_want;

   for (genvar gi = 0; gi < 4; gi++) begin : g_bl
      assign bl_tab[gi] = COL_W'((1 << gi) - 1);
   end

   assign bl_m1      = bl_tab[bl_sel];
   assign cl_eff     = (cas_lat == 2'd0) ? 2'd1 : cas_lat;
   assign trunc_want = full_page || (len_m1 < bl_m1);
   assign err        = !full_page && trunc_want && !stop_pre && auto_pre;
   assign do_stop    = trunc_want && !err;
   assign ap_bit     = !full_page && auto_pre;
   assign words_m1   = do_stop ? len_m1 : bl_m1;

   // last data word is sampled at the edge closing cycle READ+CL+words-1;
   // the stop command leads that edge by CL-1 cycles
   assign last_at = CNT_W'(cl_eff) + CNT_W'(words_m1);
   assign stop_at = last_at - CNT_W'(cl_eff) + CNT_W'(1);
endmodule

// File: rtl/sdram_rd_trunc_cmd.sv
module sdram_rd_trunc_cmd
   import sdram_rd_trunc_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9,
   parameter int ADDR_W = 13,
   parameter int AP_BIT = 10,
   parameter int CNT_W  = COL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  col,
   input  logic              ap,
   input  logic              do_stop,
   input  logic              stop_pre,
   input  logic              err_in,
   input  logic [CNT_W-1:0]  stop_at,
   input  logic [CNT_W-1:0]  last_at,
   output logic              busy,
   output logic [CNT_W-1:0]  cnt,
   output sd_cmd_e           cmd,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr,
   output logic              err
);
   logic              run_q;
   logic [CNT_W-1:0]  cnt_q, cnt_nxt, stop_at_q, last_at_q;
   logic              do_stop_q, pre_q, err_q;
   logic [BANK_W-1:0] bank_q, ba_q;
   logic [ADDR_W-1:0] addr_q, rd_addr;
   sd_cmd_e           cmd_q;

   assign cnt_nxt = cnt_q + CNT_W'(1);

   always_comb begin
      rd_addr = '0;
      rd_addr[COL_W-1:0] = col;
      rd_addr[AP_BIT]    = ap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         cnt_q     <= '0;
         stop_at_q <= '0;
         last_at_q <= '0;
         do_stop_q <= 1'b0;
         pre_q     <= 1'b0;
         bank_q    <= '0;
         cmd_q     <= CMD_NOP;
         ba_q      <= '0;
         addr_q    <= '0;
         err_q     <= 1'b0;
      end else begin
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         err_q  <= 1'b0;
         if (start) begin
            run_q     <= 1'b1;
            cnt_q     <= '0;
            stop_at_q <= stop_at;
            last_at_q <= last_at;
            do_stop_q <= do_stop;
            pre_q     <= stop_pre;
            bank_q    <= bank;
            cmd_q     <= CMD_READ;
            ba_q      <= bank;
            addr_q    <= rd_addr;
            err_q     <= err_in;
         end else if (run_q) begin
            cnt_q <= cnt_nxt;
            if (cnt_q == last_at_q) run_q <= 1'b0;
            if (do_stop_q && cnt_nxt == stop_at_q) begin
               cmd_q <= pre_q ? CMD_PRE : CMD_BST;
               if (pre_q) ba_q <= bank_q;
            end
         end
      end
   end

   assign busy = run_q;
   assign cnt  = cnt_q;
   assign cmd  = cmd_q;
   assign ba   = ba_q;
   assign addr = addr_q;
   assign err  = err_q;
endmodule

// File: rtl/sdram_rd_trunc_cap.sv
module sdram_rd_trunc_cap #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        cl,
   input  logic [CNT_W-1:0]  last_at,
   input  logic              busy,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] dq,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              last
);
   logic [1:0]       cl_q;
   logic [CNT_W-1:0] last_q;
   logic             in_win;

   assign in_win = busy && !start && (cnt >= CNT_W'(cl_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl_q   <= 2'd1;
         last_q <= '0;
         valid  <= 1'b0;
         data   <= '0;
         last   <= 1'b0;
      end else begin
         if (start) begin
            cl_q   <= cl;
            last_q <= last_at;
         end
         valid <= in_win;
         last  <= in_win && (cnt == last_q);
         if (in_win) data <= dq;
      end
   end
endmodule

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc
   import sdram_rd_trunc_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9,
   parameter int ADDR_W = 13,
   parameter int AP_BIT = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_cas_lat,
   input  logic [1:0]        cfg_bl_sel,
   input  logic              cfg_full_page,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic [COL_W-1:0]  req_len_m1,
   input  logic              req_stop_pre,
   input  logic              req_auto_pre,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DATA_W/8-1:0] sd_dqm,
   input  logic [DATA_W-1:0] sd_dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              trunc_err
);
   localparam int CNT_W = COL_W + 2;
   localparam int DQM_W = DATA_W / 8;

   if (COL_W < 3) begin : g_bad_col
      $error("COL_W must cover the longest fixed burst");
   end
   if (AP_BIT >= ADDR_W || AP_BIT < COL_W) begin : g_bad_ap
      $error("AP_BIT must lie above the column field inside the address bus");
   end
   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("DATA_W must be a whole number of bytes");
   end

   logic [1:0]       cl_eff;
   logic             ap_bit, do_stop, err_c, busy, start;
   logic [CNT_W-1:0] last_at, stop_at, cnt;
   sd_cmd_e          cmd;

   assign req_ready = !busy;
   assign start     = req_valid && req_ready;

   sdram_rd_trunc_plan #(.COL_W(COL_W), .CNT_W(CNT_W)) u_plan (
      .cas_lat  (cfg_cas_lat),
      .bl_sel   (cfg_bl_sel),
      .full_page(cfg_full_page),
      .len_m1   (req_len_m1),
      .stop_pre (req_stop_pre),
      .auto_pre (req_auto_pre),
      .cl_eff   (cl_eff),
      .ap_bit   (ap_bit),
      .do_stop  (do_stop),
      .err      (err_c),
      .last_at  (last_at),
      .stop_at  (stop_at)
   );

   sdram_rd_trunc_cmd #(
      .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
      .AP_BIT(AP_BIT), .CNT_W(CNT_W)
   ) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .bank    (req_bank),
      .col     (req_col),
      .ap      (ap_bit),
      .do_stop (do_stop),
      .stop_pre(req_stop_pre),
      .err_in  (err_c),
      .stop_at (stop_at),
      .last_at (last_at),
      .busy    (busy),
      .cnt     (cnt),
      .cmd     (cmd),
      .ba      (sd_ba),
      .addr    (sd_addr),
      .err     (trunc_err)
   );

   sdram_rd_trunc_cap #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cl     (cl_eff),
      .last_at(last_at),
      .busy   (busy),
      .cnt    (cnt),
      .dq     (sd_dq_in),
      .valid  (rd_valid),
      .data   (rd_data),
      .last   (rd_last)
   );

   assign sd_cs_n = 1'b0;
   assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign sd_dqm = {DQM_W{1'b0}};
endmodule

// File: rtl/sdram_rd_trunc_chk.sv
module sdram_rd_trunc_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [COL_W-1:0] req_len_m1,
   input logic             sd_ras_n,
   input logic             sd_cas_n,
   input logic             sd_we_n,
   input logic             rd_valid,
   input logic             rd_last,
   input logic             trunc_err
);
   localparam int K_W = COL_W + 2;

   logic [2:0]       cmd;
   logic             is_read, is_stop, accept;
   logic [K_W-1:0]   since_rd;
   logic [COL_W-1:0] len_l;

   assign cmd     = {sd_ras_n, sd_cas_n, sd_we_n};
   assign is_read = (cmd == 3'b101);
   assign is_stop = (cmd == 3'b110) || (cmd == 3'b010);
   assign accept  = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rd <= '0;
         len_l    <= '0;
      end else begin
         if (accept) len_l <= req_len_m1;
         if (is_read) since_rd <= K_W'(1);
         else if (since_rd != {K_W{1'b1}}) since_rd <= since_rd + K_W'(1);
      end
   end

   // R1
   read_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> is_read);
   // R1
   read_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_read |-> $past(accept));
   // R2
   stop_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_stop |-> (since_rd == K_W'(len_l) + K_W'(1)));
   // R5
   err_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trunc_err |-> is_read);
   // R7
   legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_read || is_stop || cmd == 3'b111);
   // R10
   last_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> (rd_valid && req_ready));
   // R10
   busy_no_data_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> rd_last);
endmodule

bind sdram_rd_trunc sdram_rd_trunc_chk #(.COL_W(COL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_len_m1(req_len_m1),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .rd_valid  (rd_valid),
   .rd_last   (rd_last),
   .trunc_err (trunc_err)
);

// File: tb/tb_sdram_rd_trunc.sv
`timescale 1ns/1ps
module tb_sdram_rd_trunc;
   localparam int BANK_W = 2;
   localparam int COL_W  = 9;
   localparam int ADDR_W = 13;
   localparam int AP_BIT = 10;
   localparam int DATA_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cfg_cas_lat = 2'd2;
   logic [1:0] cfg_bl_sel = 2'd3;
   logic cfg_full_page = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [BANK_W-1:0] req_bank = '0;
   logic [COL_W-1:0] req_col = '0;
   logic [COL_W-1:0] req_len_m1 = '0;
   logic req_stop_pre = 1'b0;
   logic req_auto_pre = 1'b0;
   logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [BANK_W-1:0] sd_ba;
   logic [ADDR_W-1:0] sd_addr;
   logic [DATA_W/8-1:0] sd_dqm;
   logic [DATA_W-1:0] sd_dq_in;
   logic rd_valid, rd_last, trunc_err;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DATA_W-1:0] pat(int t);
      return DATA_W'(t) ^ 16'h5A00;
   endfunction
   assign sd_dq_in = pat(cyc);

   sdram_rd_trunc #(
      .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
      .AP_BIT(AP_BIT), .DATA_W(DATA_W)
   ) dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // scoreboard state
   typedef struct { logic [DATA_W-1:0] d; bit l; } item_t;
   item_t exp_q[$];
   int exp_words, exp_cl;
   int rd_t, rd_n, stop_n, stop_t, stop_kind, err_n, err_bad;
   int got_n, bad_data, bad_cmd, bad_dqm, bad_rdy, bad_addr;
   int exp_bank, exp_col, exp_ap;
   bit active = 0;

   // monitor, samples between edges
   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] c;
         c = {sd_ras_n, sd_cas_n, sd_we_n};
         if (sd_dqm != '0) bad_dqm++;
         if (sd_cs_n != 1'b0) bad_cmd++;
         if (c == 3'b101) begin
            rd_n++;
            rd_t = cyc;
            if (sd_ba != BANK_W'(exp_bank) || sd_addr[COL_W-1:0] != COL_W'(exp_col)
                || sd_addr[AP_BIT] != exp_ap[0]) bad_addr++;
            for (int k = 0; k < exp_words; k++) begin
               item_t it;
               it.d = pat(cyc + exp_cl + k);
               it.l = (k == exp_words - 1);
               exp_q.push_back(it);
            end
         end else if (c == 3'b110 || c == 3'b010) begin
            stop_n++;
            stop_t = cyc;
            stop_kind = int'(c);
            if (c == 3'b010 && (sd_ba != BANK_W'(exp_bank) || sd_addr[AP_BIT] != 1'b0))
               bad_addr++;
         end else if (c != 3'b111) bad_cmd++;
         if (trunc_err) begin
            err_n++;
            if (c != 3'b101) err_bad++;
         end
         if (rd_valid) begin
            got_n++;
            if (exp_q.size() == 0) bad_data++;
            else begin
               item_t it;
               it = exp_q.pop_front();
               if (rd_data != it.d || rd_last != it.l) bad_data++;
            end
            if (rd_last && !req_ready) bad_rdy++;
            if (!rd_last && req_ready) bad_rdy++;
         end else if (rd_last) bad_data++;
      end
   end

   task automatic run_req(input int cl, input int bl_sel, input bit fp, input int bank,
                          input int col, input int len_m1, input bit pre, input bit ap,
                          input int exp_stop, input int exp_err, input string tag);
      int bl, words, wd;
      bl = 1 << bl_sel;
      if (fp) words = len_m1 + 1;
      else if (len_m1 + 1 >= bl) words = bl;
      else if (!pre && ap) words = bl;
      else words = len_m1 + 1;
      exp_words = words; exp_cl = cl;
      exp_bank = bank; exp_col = col; exp_ap = (!fp && ap) ? 1 : 0;
      rd_n = 0; stop_n = 0; err_n = 0; err_bad = 0; got_n = 0;
      bad_data = 0; bad_cmd = 0; bad_dqm = 0; bad_rdy = 0; bad_addr = 0;
      stop_t = -1; stop_kind = 0;
      @(negedge clk);
      cfg_cas_lat = 2'(cl); cfg_bl_sel = 2'(bl_sel); cfg_full_page = fp;
      req_bank = BANK_W'(bank); req_col = COL_W'(col); req_len_m1 = COL_W'(len_m1);
      req_stop_pre = pre; req_auto_pre = ap; req_valid = 1'b1;
      chk(req_ready == 1'b1, {tag, " R10 ready before request"}, int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, {tag, " R10 busy after accept"}, int'(req_ready), 0);
      wd = 0;
      while (!(req_ready && exp_q.size() == 0 && got_n > 0) && wd < 2000) begin
         @(negedge clk);
         wd++;
      end
      chk(wd < 2000, {tag, " R10 completion"}, wd, 0);
      repeat (3) @(negedge clk);
      chk(rd_n == 1, {tag, " R1 one READ"}, rd_n, 1);
      chk(bad_addr == 0, {tag, " R1/R4 bank/column/A10"}, bad_addr, 0);
      chk(got_n == words, {tag, " R9 word count"}, got_n, words);
      chk(bad_data == 0, {tag, " R9 data/last order"}, bad_data, 0);
      chk(bad_rdy == 0, {tag, " R10 ready with last word"}, bad_rdy, 0);
      chk(bad_cmd == 0, {tag, " R7 idle cycles NOP"}, bad_cmd, 0);
      chk(bad_dqm == 0, {tag, " R8 dqm low"}, bad_dqm, 0);
      chk(err_n == exp_err && err_bad == 0, {tag, " R5 error pulse"}, err_n, exp_err);
      if (exp_stop == 0) begin
         chk(stop_n == 0, {tag, " R6 no stop"}, stop_n, 0);
      end else begin
         chk(stop_n == 1, {tag, " R2 one stop"}, stop_n, 1);
         chk(stop_t - rd_t == len_m1 + 1, {tag, " R2 stop offset"}, stop_t - rd_t, len_m1 + 1);
         chk(stop_kind == (pre ? 3'b010 : 3'b110), {tag, " R4 stop kind"}, stop_kind,
             pre ? 2 : 6);
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R11 cmd NOP in reset",
          int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
      chk(req_ready == 1'b1, "R11 ready in reset", int'(req_ready), 1);
      chk(!rd_valid && !rd_last && !trunc_err, "R11 outputs low in reset",
          int'({rd_valid, rd_last, trunc_err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R2 across latencies, fixed BL8, four words
      run_req(1, 3, 0, 1, 16, 3, 0, 0, 1, 0, "cl1");
      run_req(2, 3, 0, 2, 40, 3, 0, 0, 1, 0, "cl2");
      run_req(3, 3, 0, 3, 72, 3, 0, 0, 1, 0, "cl3");
      // R3 full page, with and without auto precharge request
      run_req(2, 0, 1, 0, 100, 9, 0, 0, 1, 0, "fp");
      run_req(3, 0, 1, 1, 200, 20, 0, 1, 1, 0, "fp_ap");
      run_req(1, 0, 1, 2, 5, 0, 0, 0, 1, 0, "fp_one");
      // R4 precharge stop, also legal with auto precharge
      run_req(3, 3, 0, 2, 8, 2, 1, 0, 1, 0, "pre");
      run_req(2, 2, 0, 3, 12, 1, 1, 1, 1, 0, "pre_ap");
      // R5 refused burst stop
      run_req(2, 2, 0, 1, 32, 1, 0, 1, 0, 1, "err");
      // R6 count at or above burst length
      run_req(2, 2, 0, 0, 64, 3, 0, 0, 0, 0, "bl_eq");
      run_req(3, 1, 0, 1, 80, 10, 0, 1, 0, 0, "bl_over");
      run_req(1, 0, 0, 2, 90, 0, 0, 0, 0, 0, "bl1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule